// File: doc/BRIEF.md
# Deferred Group-7 Fault Dispatcher

This block holds the asynchronous group-7 fault requests of a processor (connect, timer runout, execute, and others) together with an optional set of three floating faults. Requests land in a preset register and do not affect the pending state until the instruction sequencer pulses an advance strobe at an instruction boundary. On advance, the presets merge into the pending registers and the presets are cleared. Two level outputs tell the sequencer whether any fault is pending. The second of them disregards timer runout, so the sequencer can test it where that fault is masked.

When the sequencer pulses the dispatch strobe, the block picks one pending fault in a fixed order. That order is connect first, then timer runout (only when the allow flag is high), then execute, then the floating faults when legacy mode is on. The chosen pending bit is cleared. The fault number, a floating-fault flag and a subtype are presented for exactly one cycle. If nothing qualifies, the block reports the trouble fault and carries the whole pending bitmap as its subtype. A separate clear input drops only a pending timer runout.

Top module: `g7_fault_dispatch`

## Requirements
- R1: After synchronous reset, both pending outputs and `disp_valid` are 0, and no fault is held in either the preset or the pending state.
- R2: A set request (`set_req`, fault number `set_num`) marks fault `set_num` in the preset state only. The pending outputs do not change until a later `adv`. A set that arrives in the same cycle as `adv` is kept for the next advance.
- R3: On `adv`, every preset fault becomes pending (OR) and the preset state is cleared. The floating preset advances only when `legacy_mode` is 1 at that edge; otherwise it keeps its contents.
- R4: `any_pend` is 1 when any group-7 fault is pending, or when `legacy_mode` is 1 and any floating fault is pending. `any_pend_no_tmr` follows the same rule with fault 4 (timer runout) left out.
- R5: A `disp` pulse sets `disp_valid` for exactly the next cycle. The fault chosen is 8 (connect) if pending, else 4 if pending and `allow_tmr` is 1, else 15 (execute) if pending. The chosen pending bit is cleared. `disp_flt` is 0 for these faults.
- R6: For fault 8, `disp_sub` is the subtype most recently written with a set of fault 8 before the dispatch cycle. For faults 4 and 15, `disp_sub` is 0.
- R7: A floating request with code `flt_code` = f sets floating preset bit f/2-1 (integer division). Codes with f/2 equal to 0 are ignored. In legacy mode, after the three faults of R5, floating bits 0, 1 and 2 are tried in that order and dispatched as numbers 1, 2 and 3 with `disp_flt` = 1, clearing that floating bit.
- R8: If no fault qualifies, the dispatch reports number 31 with `disp_flt` = 0 and `disp_sub` equal to the 32-bit pending bitmap (bit n = fault n) zero-extended, and it clears nothing.
- R9: `tmr_clr` removes only pending fault 4. The other pending faults and the preset state are left as they are.
- R10: When `disp` and `adv` coincide, the choice uses the pending state from before the edge. The chosen bit is cleared and the presets are then merged in, so a preset copy of the chosen fault remains pending. When `tmr_clr` and `adv` coincide, a preset timer runout still becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 1 | Group-7 fault set request |
| set_num | input | 5 | Fault number of the set request |
| set_sub | input | 36 | Subtype stored with the set request |
| flt_req | input | 1 | Floating fault set request |
| flt_code | input | 3 | Floating fault code f, maps to bit f/2-1 |
| adv | input | 1 | Instruction-boundary advance strobe |
| disp | input | 1 | Dispatch strobe |
| allow_tmr | input | 1 | Timer runout may be dispatched |
| legacy_mode | input | 1 | Enables floating faults |
| tmr_clr | input | 1 | Clear pending timer runout |
| any_pend | output | 1 | Some fault pending |
| any_pend_no_tmr | output | 1 | Some fault other than timer runout pending |
| disp_valid | output | 1 | Dispatch result valid (one cycle after `disp`) |
| disp_num | output | 5 | Dispatched fault number |
| disp_flt | output | 1 | Dispatched fault is a floating fault |
| disp_sub | output | 36 | Subtype of the dispatched fault |

## Verification
The hardest situations to reach are the ones where several events meet on one edge. Examples are a dispatch that clears connect while an advance brings in a fresh preset connect, or a timer clear arriving together with an advance. Another is a floating fault that was advanced while legacy mode was off and stays hidden until the mode is turned on and another advance happens. Directed sequences arrange each of these with presets loaded one cycle earlier. A long run of random strobes, biased toward faults 4, 8 and 15, then compares the bench model against the ports on every cycle.

// File: rtl/g7_pkg.sv
package g7_pkg;
  // where the dispatched subtype comes from
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_MAP  = 2'd2
  } sub_src_e;
endpackage

// File: rtl/g7_pend_bank.sv
module g7_pend_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         adv,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | (adv ? pre_q : '0);
      pre_q  <= (adv ? '0 : pre_q) | set_vec;
    end
  end
endmodule

// File: rtl/g7_sub_store.sv
module g7_sub_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 36,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read, old data on a same-address collision
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/g7_pick.sv
module g7_pick
  import g7_pkg::*;
#(
  parameter int NF      = 32,
  parameter int NFL     = 3,
  parameter int CON_IDX = 8,
  parameter int TMR_IDX = 4,
  parameter int EXF_IDX = 15,
  parameter int TRB_IDX = 31,
  localparam int NW     = $clog2(NF)
) (
  input  logic [NF-1:0]  pend,
  input  logic [NFL-1:0] fpend,
  input  logic           allow_tmr,
  input  logic           legacy,
  output logic [NW-1:0]  num,
  output logic           flt,
  output logic [NF-1:0]  clr,
  output logic [NFL-1:0] fclr,
  output sub_src_e       src
);
  always_comb begin
    num  = NW'(TRB_IDX);
    flt  = 1'b0;
    clr  = '0;
    fclr = '0;
    src  = SRC_MAP;
    if (pend[CON_IDX]) begin
      num = NW'(CON_IDX);
      clr[CON_IDX] = 1'b1;
      src = SRC_MEM;
    end else if (allow_tmr && pend[TMR_IDX]) begin
      num = NW'(TMR_IDX);
      clr[TMR_IDX] = 1'b1;
      src = SRC_ZERO;
    end else if (pend[EXF_IDX]) begin
      num = NW'(EXF_IDX);
      clr[EXF_IDX] = 1'b1;
      src = SRC_ZERO;
    end else if (legacy) begin
      for (int i = NFL - 1; i >= 0; i--) begin
        if (fpend[i]) begin
          num  = NW'(i + 1);
          flt  = 1'b1;
          fclr = '0;
          fclr[i] = 1'b1;
          src  = SRC_ZERO;
        end
      end
    end
  end
endmodule

// File: rtl/g7_fault_dispatch.sv
module g7_fault_dispatch
  import g7_pkg::*;
#(
  parameter int NUM_FAULTS = 32,
  parameter int SUBW       = 36,
  parameter int NFL        = 3,
  parameter int FCODE_W    = 3,
  parameter int CON_IDX    = 8,
  parameter int TMR_IDX    = 4,
  parameter int EXF_IDX    = 15,
  parameter int TRB_IDX    = 31,
  localparam int NW        = $clog2(NUM_FAULTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_req,
  input  logic [NW-1:0]      set_num,
  input  logic [SUBW-1:0]    set_sub,
  input  logic               flt_req,
  input  logic [FCODE_W-1:0] flt_code,
  input  logic               adv,
  input  logic               disp,
  input  logic               allow_tmr,
  input  logic               legacy_mode,
  input  logic               tmr_clr,
  output logic               any_pend,
  output logic               any_pend_no_tmr,
  output logic               disp_valid,
  output logic [NW-1:0]      disp_num,
  output logic               disp_flt,
  output logic [SUBW-1:0]    disp_sub
);
  localparam logic [NUM_FAULTS-1:0] TMR_MASK = NUM_FAULTS'(1) << TMR_IDX;

  logic [NUM_FAULTS-1:0] g7_set, g7_clr, g7_pend, pick_clr;
  logic [NFL-1:0]        fl_set, fl_clr, fl_pend, pick_fclr;
  logic [FCODE_W-1:0]    fl_idx;
  logic [NW-1:0]         pick_num;
  logic                  pick_flt;
  sub_src_e              pick_src, src_q;
  logic [NUM_FAULTS-1:0] map_q;
  logic [SUBW-1:0]       mem_q;

  // one-hot decode of the set requests
  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_set_dec
    assign g7_set[g] = set_req && (set_num == NW'(g));
  end

  assign fl_idx = flt_code / FCODE_W'(2);
  for (genvar k = 0; k < NFL; k++) begin : g_flt_dec
    assign fl_set[k] = flt_req && (fl_idx == FCODE_W'(k + 1));
  end

  assign g7_clr = (disp ? pick_clr : '0) | (tmr_clr ? TMR_MASK : '0);
  assign fl_clr = disp ? pick_fclr : '0;

  g7_pend_bank #(.W(NUM_FAULTS)) u_g7_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (g7_set),
    .adv     (adv),
    .clr_vec (g7_clr),
    .pend_q  (g7_pend)
  );

  g7_pend_bank #(.W(NFL)) u_fl_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (fl_set),
    .adv     (adv && legacy_mode),
    .clr_vec (fl_clr),
    .pend_q  (fl_pend)
  );

  g7_sub_store #(.DEPTH(NUM_FAULTS), .DW(SUBW)) u_sub (
    .clk   (clk),
    .we    (set_req),
    .waddr (set_num),
    .wdata (set_sub),
    .re    (disp),
    .raddr (NW'(CON_IDX)),
    .rdata (mem_q)
  );

  g7_pick #(
    .NF(NUM_FAULTS), .NFL(NFL), .CON_IDX(CON_IDX), .TMR_IDX(TMR_IDX),
    .EXF_IDX(EXF_IDX), .TRB_IDX(TRB_IDX)
  ) u_pick (
    .pend      (g7_pend),
    .fpend     (fl_pend),
    .allow_tmr (allow_tmr),
    .legacy    (legacy_mode),
    .num       (pick_num),
    .flt       (pick_flt),
    .clr       (pick_clr),
    .fclr      (pick_fclr),
    .src       (pick_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_num   <= '0;
      disp_flt   <= 1'b0;
      src_q      <= SRC_ZERO;
      map_q      <= '0;
    end else begin
      disp_valid <= disp;
      if (disp) begin
        disp_num <= pick_num;
        disp_flt <= pick_flt;
        src_q    <= pick_src;
        map_q    <= g7_pend;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_MEM: disp_sub = mem_q;
      SRC_MAP: disp_sub = SUBW'(map_q);
      default: disp_sub = '0;
    endcase
  end

  assign any_pend        = (|g7_pend) || (legacy_mode && (|fl_pend));
  assign any_pend_no_tmr = (|(g7_pend & ~TMR_MASK)) || (legacy_mode && (|fl_pend));
endmodule

// File: rtl/g7_fault_dispatch_chk.sv
module g7_fault_dispatch_chk #(
  parameter int NUM_FAULTS = 32,
  parameter int SUBW       = 36,
  parameter int CON_IDX    = 8,
  parameter int TMR_IDX    = 4,
  parameter int EXF_IDX    = 15,
  parameter int TRB_IDX    = 31,
  localparam int NW        = $clog2(NUM_FAULTS)
) (
  input logic            clk,
  input logic            rst,
  input logic            adv,
  input logic            disp,
  input logic            allow_tmr,
  input logic            legacy_mode,
  input logic            tmr_clr,
  input logic            any_pend,
  input logic            any_pend_no_tmr,
  input logic            disp_valid,
  input logic [NW-1:0]   disp_num,
  input logic            disp_flt,
  input logic [SUBW-1:0] disp_sub
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    disp |=> disp_valid); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !disp |=> !disp_valid); // R5
  AST_TMR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (disp && !allow_tmr) |=> !(disp_num == NW'(TMR_IDX) && !disp_flt)); // R5
  AST_FLT_NEEDS_LEGACY: assert property (@(posedge clk) disable iff (rst)
    (disp && !legacy_mode) |=> !disp_flt); // R7
  AST_TRB_NOT_HIDING: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_flt && disp_num == NW'(TRB_IDX))
      |-> (!disp_sub[CON_IDX] && !disp_sub[EXF_IDX])); // R8
  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (rst)
    any_pend_no_tmr |-> any_pend); // R4
  AST_PEND_NEEDS_ADV: assert property (@(posedge clk) disable iff (rst)
    ($rose(any_pend) && $stable(legacy_mode)) |-> $past(adv)); // R2
  AST_CLR_ONLY_TMR: assert property (@(posedge clk) disable iff (rst)
    ($past(tmr_clr) && !$past(adv) && !$past(any_pend_no_tmr) && $stable(legacy_mode))
      |-> !any_pend); // R9
endmodule

bind g7_fault_dispatch g7_fault_dispatch_chk #(
  .NUM_FAULTS(NUM_FAULTS), .SUBW(SUBW), .CON_IDX(CON_IDX),
  .TMR_IDX(TMR_IDX), .EXF_IDX(EXF_IDX), .TRB_IDX(TRB_IDX)
) u_chk (.*);

// File: tb/sim_g7_fault_dispatch.sv
`timescale 1ns/1ps
module sim_g7_fault_dispatch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_req = 0, flt_req = 0, adv = 0, disp = 0;
  logic        allow_tmr = 0, legacy_mode = 0, tmr_clr = 0;
  logic [4:0]  set_num = '0;
  logic [35:0] set_sub = '0;
  logic [2:0]  flt_code = '0;
  logic        any_pend, any_pend_no_tmr, disp_valid, disp_flt;
  logic [4:0]  disp_num;
  logic [35:0] disp_sub;

  always #2 clk = ~clk;

  g7_fault_dispatch u0 (
    .clk(clk), .rst(rst), .set_req(set_req), .set_num(set_num), .set_sub(set_sub),
    .flt_req(flt_req), .flt_code(flt_code), .adv(adv), .disp(disp),
    .allow_tmr(allow_tmr), .legacy_mode(legacy_mode), .tmr_clr(tmr_clr),
    .any_pend(any_pend), .any_pend_no_tmr(any_pend_no_tmr), .disp_valid(disp_valid),
    .disp_num(disp_num), .disp_flt(disp_flt), .disp_sub(disp_sub)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  bit [31:0] m_pend, m_pre;
  bit [2:0]  m_fp, m_fpre;
  bit [35:0] m_sub [32];
  bit        e_valid, e_flt;
  int        e_num;
  bit [35:0] e_sub;

  task automatic check(string what, string tag, bit [63:0] got, bit [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic void model_edge();
    bit [31:0] clr;
    bit [2:0]  fclr;
    bit        found;
    int        fi;
    clr = 0; fclr = 0;
    e_valid = disp;
    if (disp) begin
      e_flt = 0; e_sub = 0;
      if (m_pend[8]) begin e_num = 8; e_sub = m_sub[8]; clr[8] = 1; end
      else if (allow_tmr && m_pend[4]) begin e_num = 4; clr[4] = 1; end
      else if (m_pend[15]) begin e_num = 15; clr[15] = 1; end
      else begin
        found = 0;
        if (legacy_mode)
          for (int i = 0; i < 3; i++)
            if (!found && m_fp[i]) begin
              found = 1; e_num = i + 1; e_flt = 1; fclr[i] = 1;
            end
        if (!found) begin e_num = 31; e_sub = {4'b0, m_pend}; end
      end
    end
    if (tmr_clr) clr[4] = 1;
    m_pend = m_pend & ~clr;
    if (adv) begin m_pend = m_pend | m_pre; m_pre = 0; end
    m_fp = m_fp & ~fclr;
    if (adv && legacy_mode) begin m_fp = m_fp | m_fpre; m_fpre = 0; end
    if (set_req) begin m_pre[set_num] = 1; m_sub[set_num] = set_sub; end
    fi = int'(flt_code) / 2;
    if (flt_req && fi >= 1 && fi <= 3) m_fpre[fi-1] = 1;
  endfunction

  task automatic compare(string tag);
    bit ep, en;
    ep = (m_pend != 0) || (legacy_mode && m_fp != 0);
    en = ((m_pend & ~32'h10) != 0) || (legacy_mode && m_fp != 0);
    check("any_pend", tag, 64'(any_pend), 64'(ep));
    check("any_pend_no_tmr", tag, 64'(any_pend_no_tmr), 64'(en));
    check("disp_valid", tag, 64'(disp_valid), 64'(e_valid));
    if (e_valid) begin
      check("disp_num", tag, 64'(disp_num), 64'(e_num));
      check("disp_flt", tag, 64'(disp_flt), 64'(e_flt));
      check("disp_sub", tag, 64'(disp_sub), 64'(e_sub));
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit sr, int sn, bit [35:0] ss, bit fr, int fc, bit a, bit d,
                     bit al, bit lg, bit tc, string tag);
    set_req = sr; set_num = 5'(sn); set_sub = ss; flt_req = fr; flt_code = 3'(fc);
    adv = a; disp = d; allow_tmr = al; legacy_mode = lg; tmr_clr = tc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(bit al, bit lg, string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, al, lg, 0, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_pend = 0; m_pre = 0; m_fp = 0; m_fpre = 0; e_valid = 0;
    for (int i = 0; i < 32; i++) m_sub[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");

    // R2: presets are invisible until advance
    cyc(1, 8, 36'h0ABC, 0, 0, 0, 0, 1, 0, 0, "R2");
    cyc(1, 4, 36'h0, 0, 0, 0, 0, 1, 0, 0, "R2");
    idle(1, 0, "R2");
    // R3: advance together with a new set; the new set waits
    cyc(1, 15, 36'h5, 0, 0, 1, 0, 1, 0, 0, "R3");
    idle(1, 0, "R4");
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R3");
    // R5/R6: ordering connect, timer, execute, then trouble with empty map
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R8");

    // R8: timer masked, others in map, nothing cleared
    cyc(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 20, 36'h77, 0, 0, 1, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
    // R9: clear removes only the timer bit, preset timer untouched
    cyc(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
    // R10: clear with advance keeps the preset timer
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 1, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R9");

    // R6: newest connect subtype wins; R10: dispatch with advance of same fault
    cyc(1, 8, 36'h111, 0, 0, 1, 0, 1, 0, 0, "R6");
    cyc(1, 8, 36'h222, 0, 0, 1, 0, 1, 0, 0, "R6");
    cyc(1, 8, 36'h333, 0, 0, 0, 0, 1, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R8");

    // R7: floating faults
    cyc(0, 0, 0, 1, 2, 0, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, 1, 1, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, 6, 0, 0, 1, 1, 0, "R7");
    cyc(0, 0, 0, 1, 5, 0, 0, 1, 1, 0, "R7");
    cyc(0, 0, 0, 1, 0, 1, 0, 1, 1, 0, "R3");
    idle(1, 0, "R4");
    idle(1, 1, "R4");
    cyc(1, 15, 0, 0, 0, 0, 0, 1, 1, 0, "R7");
    cyc(0, 0, 0, 1, 4, 1, 0, 1, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 1, 0, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R8");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel, num;
      sel = $urandom % 8;
      num = (sel < 2) ? 8 : (sel < 4) ? 4 : (sel < 5) ? 15 : int'($urandom % 32);
      cyc(($urandom % 3) == 0, num, {4'h0, 32'($urandom)}, ($urandom % 5) == 0,
          int'($urandom % 8), ($urandom % 4) == 0, ($urandom % 3) == 0,
          ($urandom % 2) == 0, (i / 500) % 2 == 1, ($urandom % 10) == 0, "R5");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule